// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block gathers 32 interrupt sources and steers each one to a grid of processor interrupt lines: 4 cores with 4 parent lines each. Each raw input first passes through a synchronizer. It is then conditioned as level or edge sensitive, with either polarity, and gated by a per-source enable. Finally it is ORed onto every output line that its route byte selects.

Software programs the controller over a plain 32-bit register bus with byte lanes. There are route bytes, separate set and clear registers for the enables, and polarity and edge-select registers. Each core has its own status window, which a handler reads to find out which of its routed sources are asking for service.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every route byte, the enable mask, the polarity and edge registers and every edge latch read as zero, and all 16 output lines are low.
- R2: The route byte for source n sits at byte offset n (0x00 to 0x1F). Writes honour the byte enables, where be[b] covers data bits 8b+7:8b. The bytes read back as a little-endian 32-bit word.
- R3: A write to 0x28 sets the enable bits where the data has ones, and a write to 0x2C clears them. Zero data bits leave the enables unchanged. Offset 0x24 reads the enable mask.
- R4: With edge bit 0 (register 0x34), a source is asserted while its synchronized input is high (polarity bit 0 at 0x30) or low (polarity bit 1). Writing zero to 0x34 makes every source level sensitive.
- R5: With edge bit 1, a per-source latch is set on a rising edge (polarity 0) or a falling edge (polarity 1). The latch holds after the input returns, and is cleared only by writing a one to that source's bit at 0x2C.
- R6: A route byte holds a core mask in bits 3:0 and a line mask in bits 7:4. Output irqOut[c*4+k] is the OR of the enabled, asserted sources whose route byte has core bit c and line bit k set. A byte with several bits set fans out to every selected pair.
- R7: Offset 0x40 + 8*c reads, for core c, the enabled and asserted sources that are routed to that core.
- R8: A source whose enable bit is clear reaches neither the output lines nor any status word.
- R9: Reads from unmapped offsets return zero, and writes to them (including the read-only 0x24) change no register.
- R10: A change on irqIn reaches level status no sooner than two clock edges after it is applied: the input passes through two flops first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | 32 | Raw interrupt sources |
| busSel | input | 1 | Register access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address, word aligned |
| busBe | input | 4 | Byte enables for writes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle as the request |
| irqOut | output | 16 | Output lines, index core*4+line |

## Verification
The hardest case to reach is an edge latch that has to outlive its cause. The input must toggle in edge mode, return to its idle level, and the status must still show the source. The latch must then drop only on a clear write, and must not come back when the source is enabled again. The stimulus drives the full rising and falling round trips, waiting three clocks for the synchronizer and the edge detector. It also programs a route byte with several bits set and a source with a polarity change while its input is idle, so that fan-out and immediate level-low assertion are both seen on the lines.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int SRC_CNT = 32;
  localparam int BUS_W   = 32;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ROUTE,
    RD_ENABLE,
    RD_POL,
    RD_EDGE,
    RD_STATUS
  } rdSel_e;

  typedef struct packed {
    logic   routeWe;
    logic   setWe;
    logic   clrWe;
    logic   polWe;
    logic   edgeWe;
    rdSel_e rdSel;
    logic [3:0] idx;
  } strobe_t;
endpackage

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
  import irq_route_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_CORE = 4
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] ROUTE_WORDS = WORD_W'(SRC_CNT / (BUS_W / 8));
  localparam logic [WORD_W-1:0] EN_WORD   = WORD_W'(9);
  localparam logic [WORD_W-1:0] SET_WORD  = WORD_W'(10);
  localparam logic [WORD_W-1:0] CLR_WORD  = WORD_W'(11);
  localparam logic [WORD_W-1:0] POL_WORD  = WORD_W'(12);
  localparam logic [WORD_W-1:0] EDGE_WORD = WORD_W'(13);
  localparam logic [WORD_W-1:0] STAT_WORD = WORD_W'(16);
  localparam logic [WORD_W-2:0] CORE_LIM  = (WORD_W-1)'(NUM_CORE);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] statOff;
  logic wrEn;
  logic rdEn;

  assign word    = busAddr[ADDR_W-1:2];
  assign statOff = word - STAT_WORD;
  assign wrEn    = busSel & busWr;
  assign rdEn    = busSel & ~busWr;

  always_comb begin
    stb = '0;
    if (word < ROUTE_WORDS) begin
      stb.routeWe = wrEn;
      stb.idx     = 4'(word);
      if (rdEn) stb.rdSel = RD_ROUTE;
    end else if (word == EN_WORD) begin
      if (rdEn) stb.rdSel = RD_ENABLE;
    end else if (word == SET_WORD) begin
      stb.setWe = wrEn;
    end else if (word == CLR_WORD) begin
      stb.clrWe = wrEn;
    end else if (word == POL_WORD) begin
      stb.polWe = wrEn;
      if (rdEn) stb.rdSel = RD_POL;
    end else if (word == EDGE_WORD) begin
      stb.edgeWe = wrEn;
      if (rdEn) stb.rdSel = RD_EDGE;
    end else if (word >= STAT_WORD && !statOff[0] &&
                 statOff[WORD_W-1:1] < CORE_LIM) begin
      stb.idx = 4'(statOff[WORD_W-1:1]);
      if (rdEn) stb.rdSel = RD_STATUS;
    end
  end
endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_CORE    = 4,
  parameter int NUM_LINE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      stb,
  input  logic [BUS_W-1:0]             wdata,
  input  logic [BUS_W/8-1:0]           be,
  input  logic [SRC_CNT-1:0]           irqIn,
  output logic [BUS_W-1:0]             rdata,
  output logic [NUM_CORE*NUM_LINE-1:0] irqOut,
  output logic [SRC_CNT-1:0]           enMask,
  output logic [SRC_CNT-1:0]           edgeLatch
);
  localparam int LANES       = BUS_W / 8;
  localparam int ROUTE_WORDS = SRC_CNT / LANES;
  localparam int RW_IDX_W    = $clog2(ROUTE_WORDS);
  localparam int CORE_IDX_W  = $clog2(NUM_CORE);
  localparam int LINE_BASE   = 4;

  logic [BUS_W-1:0]   laneMask;
  logic [SRC_CNT-1:0] wrBits;
  logic [SRC_CNT-1:0] setBits;
  logic [SRC_CNT-1:0] clrBits;
  logic [SRC_CNT-1:0] polReg;
  logic [SRC_CNT-1:0] edgeReg;
  logic [SRC_CNT-1:0] syncQ [SYNC_STAGES];
  logic [SRC_CNT-1:0] syncIn;
  logic [SRC_CNT-1:0] prevQ;
  logic [SRC_CNT-1:0] edgeHit;
  logic [SRC_CNT-1:0] asserted;
  logic [SRC_CNT-1:0] active;
  logic [7:0]         routeByte [SRC_CNT];
  logic [BUS_W-1:0]   routeWord [ROUTE_WORDS];
  logic [SRC_CNT-1:0] coreHit [NUM_CORE];
  logic [SRC_CNT-1:0] lineHit [NUM_LINE];

  // byte lane expansion
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneMask[8*l +: 8] = {8{be[l]}};
  end

  assign wrBits  = wdata & laneMask;
  assign setBits = stb.setWe ? wrBits : '0;
  assign clrBits = stb.clrWe ? wrBits : '0;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polReg  <= '0;
      edgeReg <= '0;
      enMask  <= '0;
    end else begin
      if (stb.polWe)  polReg  <= (polReg & ~laneMask) | wrBits;
      if (stb.edgeWe) edgeReg <= (edgeReg & ~laneMask) | wrBits;
      enMask <= (enMask | setBits) & ~clrBits;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SRC_CNT; i++) routeByte[i] <= '0;
    end else if (stb.routeWe) begin
      for (int i = 0; i < SRC_CNT; i++) begin
        if (stb.idx == 4'(i / LANES) && be[i % LANES])
          routeByte[i] <= wdata[8*(i % LANES) +: 8];
      end
    end
  end

  // input synchronizer and edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= irqIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncIn;
    end
  end

  assign syncIn  = syncQ[SYNC_STAGES-1];
  assign edgeHit = edgeReg & ((syncIn & ~prevQ & ~polReg) |
                              (~syncIn & prevQ & polReg));

  // a new edge in the same cycle as a clear is kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeLatch <= '0;
    else       edgeLatch <= (edgeLatch & ~clrBits) | edgeHit;
  end

  assign asserted = (edgeReg & edgeLatch) | (~edgeReg & (syncIn ^ polReg));
  assign active   = asserted & enMask;

  // route decode
  always_comb begin
    for (int c = 0; c < NUM_CORE; c++)
      for (int i = 0; i < SRC_CNT; i++) coreHit[c][i] = routeByte[i][c];
    for (int k = 0; k < NUM_LINE; k++)
      for (int i = 0; i < SRC_CNT; i++) lineHit[k][i] = routeByte[i][LINE_BASE+k];
    for (int w = 0; w < ROUTE_WORDS; w++)
      for (int l = 0; l < LANES; l++) routeWord[w][8*l +: 8] = routeByte[w*LANES+l];
  end

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    for (genvar k = 0; k < NUM_LINE; k++) begin : g_line
      assign irqOut[c*NUM_LINE+k] = |(active & coreHit[c] & lineHit[k]);
    end
  end

  // read mux
  always_comb begin
    unique case (stb.rdSel)
      RD_ROUTE:  rdata = routeWord[stb.idx[RW_IDX_W-1:0]];
      RD_ENABLE: rdata = enMask;
      RD_POL:    rdata = polReg;
      RD_EDGE:   rdata = edgeReg;
      RD_STATUS: rdata = active & coreHit[stb.idx[CORE_IDX_W-1:0]];
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_CORE    = 4,
  parameter int NUM_LINE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [SRC_CNT-1:0]           irqIn,
  input  logic                         busSel,
  input  logic                         busWr,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [BUS_W/8-1:0]           busBe,
  input  logic [BUS_W-1:0]             busWdata,
  output logic [BUS_W-1:0]             busRdata,
  output logic [NUM_CORE*NUM_LINE-1:0] irqOut
);
  strobe_t            stb;
  logic [SRC_CNT-1:0] enMask;
  logic [SRC_CNT-1:0] edgeLatch;

  irq_route_ctl #(
    .ADDR_W  (ADDR_W),
    .NUM_CORE(NUM_CORE)
  ) ctl_i (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .stb    (stb)
  );

  irq_route_dp #(
    .NUM_CORE   (NUM_CORE),
    .NUM_LINE   (NUM_LINE),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wdata    (busWdata),
    .be       (busBe),
    .irqIn    (irqIn),
    .rdata    (busRdata),
    .irqOut   (irqOut),
    .enMask   (enMask),
    .edgeLatch(edgeLatch)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int ADDR_W = 8,
  parameter int OUT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [3:0]        busBe,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [OUT_W-1:0]  irqOut,
  input logic [31:0]       enMask,
  input logic [31:0]       edgeLatch
);
  logic fullSet;
  logic fullClr;
  logic anyClr;
  logic holeWr;

  assign fullSet = busSel && busWr && busAddr == ADDR_W'(8'h28) && busBe == 4'hF;
  assign fullClr = busSel && busWr && busAddr == ADDR_W'(8'h2C) && busBe == 4'hF;
  assign anyClr  = busSel && busWr && busAddr == ADDR_W'(8'h2C);
  assign holeWr  = busSel && busWr && busAddr == ADDR_W'(8'h20);

  assert_set_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    fullSet |=> ((enMask & $past(busWdata)) == $past(busWdata)));

  assert_clear_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    fullClr |=> ((enMask & $past(busWdata)) == 32'h0));

  assert_latch_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    !anyClr |=> (($past(edgeLatch) & ~edgeLatch) == 32'h0));

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enMask == 32'h0) |-> (irqOut == '0));

  assert_status_enabled_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == ADDR_W'(8'h40)) |-> ((busRdata & ~enMask) == 32'h0));

  assert_hole_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    holeWr |=> $stable(enMask));
endmodule

bind irq_route_ctrl irq_route_chk #(
  .ADDR_W(ADDR_W),
  .OUT_W (NUM_CORE*NUM_LINE)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busBe    (busBe),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .irqOut   (irqOut),
  .enMask   (enMask),
  .edgeLatch(edgeLatch)
);

// File: tb/irq_route_ctrl_tb_top.sv
module irq_route_ctrl_tb_top;
  typedef struct {
    bit          isOut;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] irqOut;

  item_t sbq[$];
  int    testCount = 0;
  int    failCount = 0;
  bit    finished = 1'b0;

  always #5 clk = ~clk;

  irq_route_ctrl dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .irqIn   (irqIn),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busBe   (busBe),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .irqOut  (irqOut)
  );

  // driver tasks: start and end on a falling edge
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d; busBe = b;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busBe = '0;
  endtask

  task automatic checkRead(input logic [7:0] a, input logic [31:0] e, input string t);
    item_t it;
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    it.isOut = 1'b0; it.exp = e; it.tag = t;
    sbq.push_back(it);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic checkOut(input logic [15:0] e, input string t);
    item_t it;
    it.isOut = 1'b1; it.exp = {16'h0, e}; it.tag = t;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    item_t it;
    logic [31:0] act;
    forever begin
      wait (sbq.size() != 0);
      #1;
      it = sbq.pop_front();
      act = it.isOut ? {16'h0, irqOut} : busRdata;
      testCount++;
      if (act !== it.exp) begin
        failCount++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    checkRead(8'h00, 32'h0, "R1 route");
    checkRead(8'h24, 32'h0, "R1 enable");
    checkRead(8'h30, 32'h0, "R1 pol");
    checkRead(8'h34, 32'h0, "R1 edge");
    checkRead(8'h40, 32'h0, "R1 status");
    checkOut(16'h0, "R1 lines");

    // R2 byte lanes
    busWrite(8'h00, 32'hAAAA_AAAA, 4'b0101);
    checkRead(8'h00, 32'h00AA_00AA, "R2 lanes");
    busWrite(8'h00, 32'h2112_4111, 4'hF);
    checkRead(8'h00, 32'h2112_4111, "R2 full word");
    busWrite(8'h04, 32'h0000_5500, 4'b0010);
    checkRead(8'h04, 32'h0000_5500, "R2 byte 5");
    busWrite(8'h08, 32'h0000_3388, 4'hF);

    // R3 set/clear enables
    busWrite(8'h28, 32'h0000_030F, 4'hF);
    checkRead(8'h24, 32'h0000_030F, "R3 set");
    busWrite(8'h2C, 32'h0000_0002, 4'hF);
    checkRead(8'h24, 32'h0000_030D, "R3 clear");
    busWrite(8'h28, 32'h0, 4'hF);
    checkRead(8'h24, 32'h0000_030D, "R3 zero write");
    busWrite(8'h28, 32'h0000_0002, 4'hF);

    // R10 synchronizer delay, R4 level high
    irqIn[0] = 1'b1;
    tick(1);
    checkRead(8'h40, 32'h0, "R10 one edge");
    checkRead(8'h40, 32'h1, "R4 level high");
    checkOut(16'h0001, "R6 core0 line0");

    // R4 level low
    busWrite(8'h30, 32'h2, 4'hF);
    checkRead(8'h40, 32'h3, "R4 level low idle");
    checkOut(16'h0005, "R6 core0 line2");
    irqIn[1] = 1'b1;
    tick(3);
    checkRead(8'h40, 32'h1, "R4 level low driven");

    // R5 rising edge latch
    busWrite(8'h34, 32'h4, 4'hF);
    irqIn[2] = 1'b1;
    tick(3);
    checkRead(8'h48, 32'h4, "R5 rising");
    checkOut(16'h0011, "R6 core1 line0");
    irqIn[2] = 1'b0;
    tick(3);
    checkRead(8'h48, 32'h4, "R5 latch holds");
    busWrite(8'h2C, 32'h4, 4'hF);
    checkRead(8'h24, 32'h0000_030B, "R3 clear bit2");
    busWrite(8'h28, 32'h4, 4'hF);
    checkRead(8'h48, 32'h0, "R5 latch cleared");

    // R5 falling edge
    busWrite(8'h30, 32'hA, 4'hF);
    busWrite(8'h34, 32'hC, 4'hF);
    irqIn[3] = 1'b1;
    tick(3);
    checkRead(8'h40, 32'h1, "R5 no fall yet");
    irqIn[3] = 1'b0;
    tick(3);
    checkRead(8'h40, 32'h9, "R5 falling");
    checkOut(16'h0003, "R6 core0 line1");

    // R6 fan-out, R7 per-core status
    irqIn[8] = 1'b1;
    irqIn[9] = 1'b1;
    tick(3);
    checkOut(16'h8033, "R6 fanout");
    checkRead(8'h58, 32'h0000_0100, "R7 core3");
    checkRead(8'h48, 32'h0000_0200, "R7 core1");
    checkRead(8'h50, 32'h0, "R7 core2");

    // R8 all masked
    busWrite(8'h2C, 32'hFFFF_FFFF, 4'hF);
    checkOut(16'h0, "R8 lines");
    checkRead(8'h40, 32'h0, "R8 status");
    checkRead(8'h24, 32'h0, "R3 all cleared");

    // R9 unmapped
    busWrite(8'h20, 32'hFFFF_FFFF, 4'hF);
    busWrite(8'h38, 32'hFFFF_FFFF, 4'hF);
    busWrite(8'h60, 32'hFFFF_FFFF, 4'hF);
    busWrite(8'h24, 32'hFFFF_FFFF, 4'hF);
    checkRead(8'h24, 32'h0, "R9 enable kept");
    checkRead(8'h20, 32'h0, "R9 read 0x20");
    checkRead(8'h60, 32'h0, "R9 read 0x60");
    checkRead(8'h44, 32'h0, "R9 read 0x44");
    checkRead(8'h28, 32'h0, "R9 read 0x28");
    checkRead(8'h30, 32'h0000_000A, "R9 pol kept");
    checkRead(8'h34, 32'h0000_000C, "R9 edge kept");

    // R4 edge register zero -> level
    busWrite(8'h34, 32'h0, 4'hF);
    checkRead(8'h34, 32'h0, "R4 edge zero");
    busWrite(8'h28, 32'h8, 4'hF);
    checkRead(8'h40, 32'h8, "R4 level low src3");
    checkOut(16'h0002, "R6 src3 line");

    wait (sbq.size() == 0);
    #2;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule